// File: doc/BRIEF.md
# Tile-Map Raster Renderer

The block turns a 32-by-24 grid of tile numbers into a stream of packed pixel bytes for a framebuffer that is filled strictly in raster order. Pixels are 4-bit colour codes, two to a byte, so a 256-pixel scanline is 128 bytes. The block keeps two local memories: a tileset of 256 tiles of 8x8 pixels, and a tile map with one tile number per screen cell. A host fills both through plain write ports while no pass is running.

A pulse on `frame_start` begins one pass over all 192 scanlines. For each line the block looks up the tile number of every column, fetches that tile's 4-byte row for the current line, and hands the bytes downstream over a valid/ready pair. After the 128 picture bytes of a line it adds one zero byte that the scanout path needs. The tileset is held as whole 32-bit tile rows, so each fetched row goes straight into the stream without per-pixel work. When the last byte of the frame is taken, `done` pulses once and the block goes idle until the next `frame_start`.

Top module: `tile_map_renderer`

## Requirements
- R1: After reset `out_valid` and `done` are low.
- R2: While idle, no byte is offered and `done` stays low, including while both memories are being written.
- R3: A pass delivers exactly 192 lines of 129 accepted bytes each, that is 24768 bytes.
- R4: Picture byte `p` (0 to 127) of line `L` is the tileset byte at address `{idx[7:0], L[2:0], p[1:0]}`. Here `idx` is the map entry at address `(L/8)*32 + p/4`. The bytes of a line are sent left to right, and byte 0 of a tile row comes first.
- R5: Byte 128 of every line is the padding value 0x00.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. A byte is consumed only on a cycle where both are high.
- R7: `done` is high for exactly one cycle: the cycle after the edge at which the 24768th byte was accepted. No byte is offered afterwards until a new `frame_start`.
- R8: A `frame_start` pulse during a pass is ignored. The running pass neither restarts nor changes its output.
- R9: Tileset and map contents written between passes are used by the next pass. The high nibble of each stored byte, the left pixel, passes through unchanged.
- R10: With `out_ready` held high, once the first byte of a pass is offered, `out_valid` stays high until the last byte is accepted. Line ends add no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begins a pass when idle |
| tile_we | input | 1 | Tileset byte write enable |
| tile_waddr | input | 13 | Tileset byte address {tile, row, byte} |
| tile_wdata | input | 8 | Tileset byte (high nibble = left pixel) |
| map_we | input | 1 | Map entry write enable |
| map_waddr | input | 10 | Map address row*32+column |
| map_wdata | input | 8 | Tile number for that cell |
| out_valid | output | 1 | A stream byte is offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Stream byte |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The first pass runs with a random map, a hashed tileset and `out_ready` low about 30% of the time. This separates a correct address mapping and byte order from stalls that drop or repeat bytes. A second `frame_start` arrives mid-pass, and it would show up as a short or restarted pass. The second pass follows a full tileset rewrite and a partial map rewrite, with directed entries 0xFF, 0x80 and 0x00 in corner cells. Because `out_ready` stays high in that pass, it shows whether new contents take effect and whether the prefetch hides every memory latency, including across the padding byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_MAP  = 2'd1,
        F_TILE = 2'd2,
        F_CAP  = 2'd3
    } fetch_e;
endpackage

// File: rtl/tmr_tile_ram.sv
module tmr_tile_ram #(
    parameter int IDX_W  = 8,
    parameter int ROW_W  = 3,
    parameter int BYTE_W = 2
) (
    input  logic                            clk,
    input  logic                            we,
    input  logic [IDX_W+ROW_W+BYTE_W-1:0]   waddr,
    input  logic [7:0]                      wdata,
    input  logic [IDX_W+ROW_W-1:0]          raddr,
    output logic [8*(2**BYTE_W)-1:0]        rdata
);
    localparam int WORD_W = 8 * (2 ** BYTE_W);
    localparam int NWORDS = 2 ** (IDX_W + ROW_W);
    localparam int AW     = IDX_W + ROW_W + BYTE_W;

    logic [WORD_W-1:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr[AW-1:BYTE_W]][8*waddr[BYTE_W-1:0] +: 8] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tmr_map_ram.sv
module tmr_map_ram #(
    parameter int DEPTH = 768,
    parameter int AW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tmr_scan.sv
module tmr_scan
    import tmr_pkg::*;
#(
    parameter int COLS       = 32,
    parameter int ROWS       = 24,
    parameter int TILE_H     = 8,
    parameter int TROW_BYTES = 4,
    parameter int IDX_W      = 8,
    parameter int MAP_AW     = 10
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               frame_start,
    input  logic                               out_ready,
    output logic                               out_valid,
    output logic [7:0]                         out_data,
    output logic                               done,
    output logic [MAP_AW-1:0]                  map_raddr,
    input  logic [IDX_W-1:0]                   map_rdata,
    output logic [IDX_W+$clog2(TILE_H)-1:0]    tile_raddr,
    input  logic [8*TROW_BYTES-1:0]            tile_rdata
);
    localparam int LINES  = ROWS * TILE_H;
    localparam int LINE_W = $clog2(LINES);
    localparam int COL_W  = $clog2(COLS + 1);
    localparam int ROW_W  = $clog2(TILE_H);
    localparam int BYTE_W = $clog2(TROW_BYTES);
    localparam int WORD_W = 8 * TROW_BYTES;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              pad;
        logic              last;
    } ent_t;

    typedef struct packed {
        logic              run;
        logic [LINE_W-1:0] fline;
        logic [COL_W-1:0]  fcol;
        fetch_e            fst;
        ent_t              bufe;
        logic              buf_vld;
        ent_t              cur;
        logic              cur_vld;
        logic [BYTE_W-1:0] bidx;
        logic              done;
    } st_t;

    st_t s_d, s_q;
    logic take, accept, buf_free;
    logic [LINE_W-ROW_W-1:0] trow;
    logic [COL_W-1:0]        fcol_clamped;

    // read addresses follow the fetch pointer; both RAMs return data one cycle later
    always_comb begin
        trow         = s_q.fline[LINE_W-1:ROW_W];
        fcol_clamped = (s_q.fcol == COL_W'(COLS)) ? '0 : s_q.fcol;
        map_raddr    = MAP_AW'(trow) * MAP_AW'(COLS) + MAP_AW'(fcol_clamped);
        tile_raddr   = {map_rdata, s_q.fline[ROW_W-1:0]};
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        take     = 1'b0;
        accept   = s_q.cur_vld && out_ready;

        // emitter: walk the bytes of the current entry, refill from the buffer
        if (accept) begin
            if (s_q.cur.pad || s_q.bidx == BYTE_W'(TROW_BYTES - 1)) begin
                s_d.bidx = '0;
                if (s_q.cur.last) begin
                    s_d.done = 1'b1;
                    s_d.run  = 1'b0;
                end
                if (s_q.buf_vld) begin
                    s_d.cur     = s_q.bufe;
                    s_d.cur_vld = 1'b1;
                    take        = 1'b1;
                end else begin
                    s_d.cur_vld = 1'b0;
                end
            end else begin
                s_d.bidx = s_q.bidx + 1'b1;
            end
        end else if (!s_q.cur_vld && s_q.buf_vld) begin
            s_d.cur     = s_q.bufe;
            s_d.cur_vld = 1'b1;
            s_d.bidx    = '0;
            take        = 1'b1;
        end
        if (take) begin
            s_d.buf_vld = 1'b0;
        end
        buf_free = !s_q.buf_vld || take;

        // fetcher: map lookup, tile row read, capture into the one-entry buffer
        unique case (s_q.fst)
            F_IDLE: begin
                if (!s_q.run && frame_start) begin
                    s_d.run   = 1'b1;
                    s_d.fline = '0;
                    s_d.fcol  = '0;
                    s_d.fst   = F_MAP;
                end
            end
            F_MAP: begin
                if (s_q.fcol == COL_W'(COLS)) begin
                    if (buf_free) begin
                        s_d.bufe.word = '0;
                        s_d.bufe.pad  = 1'b1;
                        s_d.bufe.last = (s_q.fline == LINE_W'(LINES - 1));
                        s_d.buf_vld   = 1'b1;
                        s_d.fcol      = '0;
                        if (s_q.fline == LINE_W'(LINES - 1)) begin
                            s_d.fst = F_IDLE;
                        end else begin
                            s_d.fline = s_q.fline + 1'b1;
                        end
                    end
                end else begin
                    s_d.fst = F_TILE;
                end
            end
            F_TILE: begin
                s_d.fst = F_CAP;
            end
            F_CAP: begin
                if (buf_free) begin
                    s_d.bufe.word = tile_rdata;
                    s_d.bufe.pad  = 1'b0;
                    s_d.bufe.last = 1'b0;
                    s_d.buf_vld   = 1'b1;
                    s_d.fcol      = s_q.fcol + 1'b1;
                    s_d.fst       = F_MAP;
                end
            end
            default: s_d.fst = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.cur_vld;
    assign out_data  = s_q.cur.word[8*s_q.bidx +: 8];
    assign done      = s_q.done;

    // R6: an offered byte is held until taken
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R7: end-of-pass pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the pulse follows a handshake
    a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready));

    // R2: bytes are offered only inside a pass
    a_r2_valid_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> s_q.run);

    // R5: the padding entry carries a zero byte
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && s_q.cur.pad |-> out_data == 8'h00);
endmodule

// File: rtl/tile_map_renderer.sv
module tile_map_renderer #(
    parameter int COLS       = 32,
    parameter int ROWS       = 24,
    parameter int TILE_H     = 8,
    parameter int TROW_BYTES = 4,
    parameter int NTILES     = 256,
    localparam int IDX_W     = $clog2(NTILES),
    localparam int ROW_W     = $clog2(TILE_H),
    localparam int BYTE_W    = $clog2(TROW_BYTES),
    localparam int TILE_AW   = IDX_W + ROW_W + BYTE_W,
    localparam int MAP_DEPTH = COLS * ROWS,
    localparam int MAP_AW    = $clog2(MAP_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               tile_we,
    input  logic [TILE_AW-1:0] tile_waddr,
    input  logic [7:0]         tile_wdata,
    input  logic               map_we,
    input  logic [MAP_AW-1:0]  map_waddr,
    input  logic [IDX_W-1:0]   map_wdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               done
);
    localparam int WORD_W = 8 * TROW_BYTES;

    logic [MAP_AW-1:0]      map_raddr;
    logic [IDX_W-1:0]       map_rdata;
    logic [IDX_W+ROW_W-1:0] tile_raddr;
    logic [WORD_W-1:0]      tile_rdata;

    tmr_map_ram #(
        .DEPTH (MAP_DEPTH),
        .AW    (MAP_AW),
        .DW    (IDX_W)
    ) u_map (
        .clk   (clk),
        .we    (map_we),
        .waddr (map_waddr),
        .wdata (map_wdata),
        .raddr (map_raddr),
        .rdata (map_rdata)
    );

    tmr_tile_ram #(
        .IDX_W  (IDX_W),
        .ROW_W  (ROW_W),
        .BYTE_W (BYTE_W)
    ) u_tiles (
        .clk   (clk),
        .we    (tile_we),
        .waddr (tile_waddr),
        .wdata (tile_wdata),
        .raddr (tile_raddr),
        .rdata (tile_rdata)
    );

    tmr_scan #(
        .COLS       (COLS),
        .ROWS       (ROWS),
        .TILE_H     (TILE_H),
        .TROW_BYTES (TROW_BYTES),
        .IDX_W      (IDX_W),
        .MAP_AW     (MAP_AW)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .done        (done),
        .map_raddr   (map_raddr),
        .map_rdata   (map_rdata),
        .tile_raddr  (tile_raddr),
        .tile_rdata  (tile_rdata)
    );
endmodule

// File: tb/tile_map_renderer_test.sv
`timescale 1ns/1ps
module tile_map_renderer_test;
    localparam int FRAME = 192 * 129;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       tile_we = 1'b0;
    logic [12:0] tile_waddr = '0;
    logic [7:0] tile_wdata = '0;
    logic       map_we = 1'b0;
    logic [9:0] map_waddr = '0;
    logic [7:0] map_wdata = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       done;

    tile_map_renderer uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .tile_we(tile_we), .tile_waddr(tile_waddr), .tile_wdata(tile_wdata),
        .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
    );

    always #2.5 clk = ~clk;

    int errs = 0, chks = 0, cyc = 0;
    logic [7:0] map_m [768];
    logic [31:0] salt;
    bit rdy_rand = 0, rdy_fixed = 0, mon_en = 0, post_win = 0;
    int acc_cnt, tile_err, pad_err, hold_err, gap_cnt, done_cnt, done_err, post_valid, idle_bad;
    bit prev_stall, prev_final;
    logic [7:0] prev_data;

    function automatic logic [7:0] tfun(int a, logic [31:0] s);
        logic [31:0] v;
        v = (32'(a) * 32'h9E3779B1) ^ s;
        return v[31:24] ^ v[23:16] ^ v[7:0];
    endfunction

    function automatic logic [7:0] exp_byte(int k);
        int line, pos, col, b;
        line = k / 129;
        pos  = k % 129;
        if (pos == 128) return 8'h00;
        col = pos / 4;
        b   = pos % 4;
        return tfun(int'(map_m[(line / 8) * 32 + col]) * 32 + (line % 8) * 4 + b, salt);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            chks++;
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            summary_and_end();
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = rdy_rand ? ($urandom_range(99) < 70) : rdy_fixed;
        end
    end

    always @(negedge clk) begin
        if (!mon_en && rst_n && (out_valid || done)) idle_bad++;
        if (mon_en) begin
            if (prev_stall && (!out_valid || out_data != prev_data)) hold_err++;
            if (done) begin
                done_cnt++;
                if (!prev_final) done_err++;
            end
            if (post_win && out_valid) post_valid++;
            if (!post_win && !rdy_rand && acc_cnt > 0 && acc_cnt < FRAME && !out_valid) gap_cnt++;
            prev_final = 1'b0;
            if (out_valid && out_ready) begin
                if (out_data !== exp_byte(acc_cnt)) begin
                    if (acc_cnt % 129 == 128) pad_err++; else tile_err++;
                    if (tile_err + pad_err <= 3)
                        $display("mismatch byte %0d got %02h want %02h", acc_cnt, out_data, exp_byte(acc_cnt));
                end
                acc_cnt++;
                prev_final = (acc_cnt == FRAME);
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic clear_mon();
        acc_cnt = 0; tile_err = 0; pad_err = 0; hold_err = 0; gap_cnt = 0;
        done_cnt = 0; done_err = 0; post_valid = 0;
        prev_stall = 0; prev_final = 0; post_win = 0;
    endtask

    task automatic load_tiles();
        for (int a = 0; a < 8192; a++) begin
            @(posedge clk); #1;
            tile_we = 1'b1; tile_waddr = 13'(a); tile_wdata = tfun(a, salt);
        end
        @(posedge clk); #1;
        tile_we = 1'b0;
    endtask

    task automatic put_map(int a, logic [7:0] v);
        @(posedge clk); #1;
        map_we = 1'b1; map_waddr = 10'(a); map_wdata = v;
        map_m[a] = v;
        @(posedge clk); #1;
        map_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1;
        frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic finish_pass(string tag);
        wait (done_cnt >= 1);
        post_win = 1'b1;
        repeat (40) @(posedge clk);
        #1;
        check(acc_cnt == FRAME, {"R3 byte count ", tag}, acc_cnt, FRAME);
        check(tile_err == 0, {"R4 tile bytes ", tag}, tile_err, 0);
        check(pad_err == 0, {"R5 pad bytes ", tag}, pad_err, 0);
        check(done_cnt == 1, {"R7 done count ", tag}, done_cnt, 1);
        check(done_err == 0, {"R7 done timing ", tag}, done_err, 0);
        check(post_valid == 0, {"R7 idle after done ", tag}, post_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd20201024));
        clear_mon();
        idle_bad = 0;
        repeat (4) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        rst_n = 1'b1;

        // first contents: random map, hashed tileset
        salt = $urandom();
        for (int a = 0; a < 768; a++) begin
            @(posedge clk); #1;
            map_m[a] = 8'($urandom());
            map_we = 1'b1; map_waddr = 10'(a); map_wdata = map_m[a];
        end
        @(posedge clk); #1;
        map_we = 1'b0;
        load_tiles();
        repeat (5) @(posedge clk);
        #1;
        check(idle_bad == 0, "R2 quiet while idle", idle_bad, 0);

        // pass 1: random backpressure, restart attempt mid-pass
        clear_mon();
        mon_en = 1'b1;
        rdy_rand = 1'b1;
        pulse_start();
        wait (acc_cnt >= 5000);
        pulse_start();
        finish_pass("pass1");
        check(hold_err == 0, "R6 stall hold", hold_err, 0);
        check(acc_cnt == FRAME && tile_err == 0, "R8 restart ignored", acc_cnt, FRAME);
        mon_en = 1'b0;
        rdy_rand = 1'b0;
        rdy_fixed = 1'b1;

        // new contents between passes
        salt = $urandom();
        load_tiles();
        put_map(0, 8'hFF);
        put_map(31, 8'h80);
        put_map(767, 8'h00);
        for (int i = 0; i < 64; i++) put_map($urandom_range(767), 8'($urandom()));

        // pass 2: ready held high
        clear_mon();
        mon_en = 1'b1;
        pulse_start();
        finish_pass("pass2");
        check(tile_err == 0 && pad_err == 0, "R9 rewritten contents used", tile_err + pad_err, 0);
        check(gap_cnt == 0, "R10 no gaps with ready high", gap_cnt, 0);
        mon_en = 1'b0;

        summary_and_end();
    end
endmodule